// File: doc/BRIEF.md
# Parallel Port Host Register Interface

This block is the host-facing register file of a PC-style parallel port. It serves two modes: a standard mode and an enhanced mode in which the host runs address and data cycles that the peripheral paces with a ready line. A simple I/O bus reaches the block. The bus has a small address offset, active-low read and write strobes and an 8-bit data path. Offset 0 is the data port, which drives the eight peripheral data pins. Offset 1 is the status port, which reports the peripheral status lines.

All bus strobes and peripheral inputs are brought into the system clock domain before use. Edges of the strobes are detected in that domain. A write takes effect when the write strobe rises. Reading the data port returns the live pin values, not the value last written. The status byte is frozen when a read begins and stays constant until that read ends.

In enhanced mode a timer watches each bus cycle. If the peripheral fails to answer within a parameterised number of clock cycles, the timer raises a sticky timeout flag in status bit 0. Software clears the flag by writing a one to that bit. In standard mode the timer stays idle and the flag reads as zero.

Top module: `pp_host_regs`

## Requirements
- R1: After reset the data latch and `pd_out` are 0x00, the timeout flag is 0, and `bus_rdata` is 0x00 while no read is open.
- R2: A write to offset 0 changes `pd_out` to the written byte, without inversion, only once the write strobe has risen. While the strobe is still low, `pd_out` keeps its old value.
- R3: While a read of offset 0 is open, `bus_rdata` follows the live `pd_in` pins, including changes made during the read, and is independent of the latched `pd_out` value.
- R4: A read of offset 1 returns the status byte: bit 0 timeout flag, bits 1 and 2 always 0, bit 3 `pin_err_n`, bit 4 `pin_select`, bit 5 `pin_paper_end`, bit 6 `pin_ack_n`, bit 7 the inverse of `pin_busy`.
- R5: The status byte is captured when a read strobe is first seen low. It stays unchanged for that whole read even if the status pins move. The next read shows the new pin values.
- R6: In enhanced mode (`mode_epp`=1), the timeout flag becomes 1 once `epp_cycle` has been high with `epp_ready` low for `TMO_CYCLES` consecutive clocks. A cycle that ends sooner leaves the flag at 0.
- R7: The timeout flag stays 1 after the stalled cycle ends. Writing a byte with bit 0 = 1 to offset 1 clears it. Writing bit 0 = 0 leaves it set. A new timeout in the same clock as a clear wins.
- R8: In standard mode (`mode_epp`=0), the timer is held idle and the flag is forced to 0. Status bit 0 then reads 0 even during a long stall, and a flag set earlier is lost.
- R9: Writes to offset 1 or to unmapped offsets leave `pd_out` unchanged. A read of an unmapped offset returns 0x00.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_epp | input | 1 | 1 = enhanced mode with timeout timer, 0 = standard mode |
| bus_addr | input | ADDR_W | Register offset of the current bus access |
| bus_rd_n | input | 1 | Active-low read strobe (asynchronous) |
| bus_wr_n | input | 1 | Active-low write strobe (asynchronous) |
| bus_wdata | input | 8 | Write data from the host |
| bus_rdata | output | 8 | Read data to the host, 0x00 outside a read |
| pd_out | output | 8 | Peripheral data pins, driven from the data latch |
| pd_in | input | 8 | Live peripheral data pin values |
| pin_err_n | input | 1 | Peripheral error line, active low |
| pin_select | input | 1 | Peripheral selected line |
| pin_paper_end | input | 1 | Peripheral out-of-paper line |
| pin_ack_n | input | 1 | Peripheral acknowledge line, active low |
| pin_busy | input | 1 | Peripheral busy line |
| epp_cycle | input | 1 | Enhanced-mode bus cycle in progress |
| epp_ready | input | 1 | Peripheral has answered the current cycle |

## Verification
The data port is tried with a latched value that differs from the pins. This separates a live pin read from a read of the latch. The bus value is also sampled while the write strobe is still low, which separates a commit on the rising edge from a commit on the falling edge. The status port is driven with several pin patterns, each with bits at different levels, so that a swapped or inverted field shows up. The pins are also toggled inside an open read, which separates a frozen capture from a live path. The timer is given a stall somewhat shorter and one somewhat longer than its limit, then zero and one clear writes, then a mode switch. Together these separate threshold, stickiness, clear polarity and the standard-mode override.

// File: rtl/pp_pkg.sv
// Package: shared constants and the status byte packing for the parallel
// port host register interface. Assumes an 8-bit register data path.
package pp_pkg;
    localparam int BYTE_W      = 8;
    localparam int OFS_DATA    = 0;
    localparam int OFS_STATUS  = 1;
    localparam int ST_TMO_BIT  = 0;

    // Pack the status byte from the timeout flag and the synchronised pins.
    function automatic logic [BYTE_W-1:0] pack_status(
        input logic tmo,
        input logic err_n,
        input logic sel,
        input logic paper_end,
        input logic ack_n,
        input logic busy
    );
        logic [BYTE_W-1:0] s;
        s    = '0;
        s[0] = tmo;
        s[3] = err_n;
        s[4] = sel;
        s[5] = paper_end;
        s[6] = ack_n;
        s[7] = ~busy;
        return s;
    endfunction
endpackage

// File: rtl/pp_sync_bank.sv
// Module: multi-bit, multi-stage synchroniser bank.
// Each bit passes through STAGES flops. The bits are independent, so it is
// meant for single-bit strobes and slow level lines, not for buses.
module pp_sync_bank #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            // Shift one stage of the synchroniser chain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stg[i] <= RST_VAL;
                end else if (i == 0) begin
                    stg[i] <= d;
                end else begin
                    stg[i] <= stg[(i == 0) ? 0 : i-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/pp_strobe_edge.sv
// Module: edge detector for one synchronised active-low strobe.
// Produces one-cycle pulses when the strobe is first seen low (assert) and
// first seen high again (release). Assumes the input is already synchronised.
module pp_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_n_s,
    output logic assert_pulse,
    output logic release_pulse
);
    logic prev_n;

    // Remember the previous strobe level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_n <= 1'b1;
        end else begin
            prev_n <= strobe_n_s;
        end
    end

    assign assert_pulse  =  prev_n & ~strobe_n_s;
    assign release_pulse = ~prev_n &  strobe_n_s;
endmodule

// File: rtl/pp_epp_timeout.sv
// Module: enhanced-mode bus timeout timer with a sticky flag.
// Counts consecutive clocks in which a cycle is open and the peripheral has
// not answered. The flag sets after TMO_CYCLES such clocks. It is cleared by
// clear_req or forced low in standard mode. A set wins over a clear.
// Assumes the cycle and ready inputs are synchronised.
module pp_epp_timeout #(
    parameter int TMO_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_epp,
    input  logic cyc_s,
    input  logic ready_s,
    input  logic clear_req,
    output logic flag
);
    localparam int CW = $clog2(TMO_CYCLES + 1);

    logic [CW-1:0] cnt;
    logic          stalled;
    logic          fire;

    assign stalled = mode_epp & cyc_s & ~ready_s;
    assign fire    = stalled && (cnt == CW'(TMO_CYCLES - 1));

    // Count stalled clocks, saturating at the limit, else restart at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!stalled) begin
            cnt <= '0;
        end else if (cnt != CW'(TMO_CYCLES)) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Keep the sticky timeout flag: forced low in standard mode, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (!mode_epp) begin
            flag <= 1'b0;
        end else if (fire) begin
            flag <= 1'b1;
        end else if (clear_req) begin
            flag <= 1'b0;
        end
    end
endmodule

// File: rtl/pp_status_port.sv
// Module: status read capture. Freezes the live status byte on the clock
// where a read strobe is first seen low. Holds it, and marks the read open,
// until the strobe is seen high again.
module pp_status_port #(
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_start,
    input  logic          rd_end,
    input  logic [BW-1:0] live,
    output logic [BW-1:0] hold,
    output logic          holding
);
    // Capture the status byte at the start of each read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold <= '0;
        end else if (rd_start) begin
            hold <= live;
        end
    end

    // Track whether a read is currently open.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            holding <= 1'b0;
        end else if (rd_start) begin
            holding <= 1'b1;
        end else if (rd_end) begin
            holding <= 1'b0;
        end
    end
endmodule

// File: rtl/pp_host_regs.sv
// Module: parallel port host register interface (top).
// Offset 0 is the data port: the latch drives pd_out, and reads return the
// live pd_in pins. Offset 1 is the status port: reads return a byte frozen
// at read start. The enhanced-mode timeout flag is write-one-to-clear.
// Assumes bus_addr and bus_wdata stay stable from strobe fall until
// SYNC_STAGES+2 clocks after the strobe rises, and that mode_epp is quasi-static.
module pp_host_regs #(
    parameter int ADDR_W      = 3,
    parameter int SYNC_STAGES = 2,
    parameter int TMO_CYCLES  = 1000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     mode_epp,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic                     bus_rd_n,
    input  logic                     bus_wr_n,
    input  logic [pp_pkg::BYTE_W-1:0] bus_wdata,
    output logic [pp_pkg::BYTE_W-1:0] bus_rdata,
    output logic [pp_pkg::BYTE_W-1:0] pd_out,
    input  logic [pp_pkg::BYTE_W-1:0] pd_in,
    input  logic                     pin_err_n,
    input  logic                     pin_select,
    input  logic                     pin_paper_end,
    input  logic                     pin_ack_n,
    input  logic                     pin_busy,
    input  logic                     epp_cycle,
    input  logic                     epp_ready
);
    import pp_pkg::*;

    localparam logic [ADDR_W-1:0] A_DATA   = ADDR_W'(OFS_DATA);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);

    logic       rd_n_s, wr_n_s;
    logic [4:0] pins_s;
    logic       cyc_s, ready_s;
    logic       rd_start, rd_end, wr_commit, wr_low_unused;
    logic       tmo_flag, clear_req;
    logic [BYTE_W-1:0] status_live, status_hold;
    logic       rd_holding;

    pp_sync_bank #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync_strobe (
        .clk(clk), .rst_n(rst_n),
        .d({bus_rd_n, bus_wr_n}), .q({rd_n_s, wr_n_s})
    );

    pp_sync_bank #(.W(5), .STAGES(SYNC_STAGES), .RST_VAL(5'b0)) u_sync_pins (
        .clk(clk), .rst_n(rst_n),
        .d({pin_busy, pin_ack_n, pin_paper_end, pin_select, pin_err_n}),
        .q(pins_s)
    );

    pp_sync_bank #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) u_sync_epp (
        .clk(clk), .rst_n(rst_n),
        .d({epp_cycle, epp_ready}), .q({cyc_s, ready_s})
    );

    pp_strobe_edge u_rd_edge (
        .clk(clk), .rst_n(rst_n), .strobe_n_s(rd_n_s),
        .assert_pulse(rd_start), .release_pulse(rd_end)
    );

    pp_strobe_edge u_wr_edge (
        .clk(clk), .rst_n(rst_n), .strobe_n_s(wr_n_s),
        .assert_pulse(wr_low_unused), .release_pulse(wr_commit)
    );

    assign clear_req = wr_commit && (bus_addr == A_STATUS) && bus_wdata[ST_TMO_BIT];

    pp_epp_timeout #(.TMO_CYCLES(TMO_CYCLES)) u_tmo (
        .clk(clk), .rst_n(rst_n), .mode_epp(mode_epp),
        .cyc_s(cyc_s), .ready_s(ready_s),
        .clear_req(clear_req), .flag(tmo_flag)
    );

    assign status_live = pack_status(tmo_flag & mode_epp, pins_s[0], pins_s[1],
                                     pins_s[2], pins_s[3], pins_s[4]);

    pp_status_port #(.BW(BYTE_W)) u_status (
        .clk(clk), .rst_n(rst_n),
        .rd_start(rd_start), .rd_end(rd_end),
        .live(status_live), .hold(status_hold), .holding(rd_holding)
    );

    // Latch the data port on the rising edge of a write to offset 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pd_out <= '0;
        end else if (wr_commit && (bus_addr == A_DATA)) begin
            pd_out <= bus_wdata;
        end
    end

    // Select read data: live pins, the frozen status, or zero.
    always_comb begin
        bus_rdata = '0;
        if (rd_holding) begin
            if (bus_addr == A_DATA) begin
                bus_rdata = pd_in;
            end else if (bus_addr == A_STATUS) begin
                bus_rdata = status_hold;
            end
        end
    end
endmodule

// File: rtl/pp_host_regs_chk.sv
// Module: assertion checker for pp_host_regs, attached with bind.
module pp_host_regs_chk #(
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_epp,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        bus_rdata,
    input logic [7:0]        pd_out,
    input logic              wr_commit,
    input logic              tmo_flag,
    input logic              rd_holding,
    input logic [7:0]        status_hold
);
    localparam logic [ADDR_W-1:0] A_DATA   = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(1);

    AST_DATA_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_commit && bus_addr == A_DATA) |=> (pd_out == $past(bus_wdata))); // R2

    AST_DATA_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_commit && bus_addr == A_DATA) |=> $stable(pd_out)); // R9

    AST_SPP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_epp |=> !tmo_flag); // R8

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_flag && mode_epp && !(wr_commit && bus_addr == A_STATUS && bus_wdata[0]))
        |=> tmo_flag); // R7

    AST_STATUS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_holding && $past(rd_holding)) |-> $stable(status_hold)); // R5

    AST_STATUS_GAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_holding && bus_addr == A_STATUS) |-> (bus_rdata[2:1] == 2'b00)); // R4
endmodule

bind pp_host_regs pp_host_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .mode_epp(mode_epp), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pd_out(pd_out),
    .wr_commit(wr_commit), .tmo_flag(tmo_flag), .rd_holding(rd_holding),
    .status_hold(status_hold)
);

// File: tb/pp_host_regs_bench.sv
// Scoreboard bench for pp_host_regs: driver tasks queue expected values,
// a monitor process pops them and compares against the design outputs.
module pp_host_regs_bench;
    localparam int TMO = 60;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_epp = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_rd_n = 1'b1;
    logic       bus_wr_n = 1'b1;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] pd_out;
    logic [7:0] pd_in = '0;
    logic       pin_err_n = 1'b1;
    logic       pin_select = 1'b1;
    logic       pin_paper_end = 1'b0;
    logic       pin_ack_n = 1'b1;
    logic       pin_busy = 1'b0;
    logic       epp_cycle = 1'b0;
    logic       epp_ready = 1'b0;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    typedef struct {
        bit         on_pins;
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t q[$];

    always #5 clk = ~clk;

    pp_host_regs #(.ADDR_W(3), .SYNC_STAGES(2), .TMO_CYCLES(TMO)) u_pp_host_regs (
        .clk(clk), .rst_n(rst_n), .mode_epp(mode_epp), .bus_addr(bus_addr),
        .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pd_out(pd_out), .pd_in(pd_in),
        .pin_err_n(pin_err_n), .pin_select(pin_select),
        .pin_paper_end(pin_paper_end), .pin_ack_n(pin_ack_n),
        .pin_busy(pin_busy), .epp_cycle(epp_cycle), .epp_ready(epp_ready)
    );

    function automatic logic [7:0] st(input logic tmo);
        return {~pin_busy, pin_ack_n, pin_paper_end, pin_select, pin_err_n, 2'b00, tmo};
    endfunction

    task automatic expect_item(input bit on_pins, input logic [7:0] exp, input string tag);
        item_t it;
        it.on_pins = on_pins;
        it.exp = exp;
        it.tag = tag;
        q.push_back(it);
        #1;
    endtask

    // Monitor: compare each queued expectation against the design output.
    initial begin
        forever begin
            item_t it;
            logic [7:0] act;
            wait (q.size() > 0);
            it = q.pop_front();
            act = it.on_pins ? pd_out : bus_rdata;
            checks++;
            if (act !== it.exp) begin
                fails++;
                $display("FAIL %s actual=%02h expected=%02h", it.tag, act, it.exp);
            end
        end
    end

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr_n = 1'b0;
        repeat (4) @(negedge clk);
        bus_wr_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic rd_open(input logic [2:0] a);
        @(negedge clk);
        bus_addr = a; bus_rd_n = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic rd_close();
        bus_rd_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic read_check(input logic [2:0] a, input logic [7:0] exp, input string tag);
        rd_open(a);
        expect_item(1'b0, exp, tag);
        rd_close();
    endtask

    task automatic stall(input int n);
        @(negedge clk);
        epp_cycle = 1'b1; epp_ready = 1'b0;
        repeat (n) @(negedge clk);
        epp_ready = 1'b1;
        repeat (2) @(negedge clk);
        epp_cycle = 1'b0; epp_ready = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                fails++;
                $display("FAIL watchdog actual=%0d expected=<150000", cycles);
                $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
                $finish;
            end
        end
    end

    // Driver: stimulus sequence per requirement.
    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        expect_item(1'b1, 8'h00, "R1 pd_out after reset");
        expect_item(1'b0, 8'h00, "R1 rdata idle");
        read_check(3'd1, st(1'b0), "R1 status after reset");

        bus_write(3'd0, 8'hA5);
        expect_item(1'b1, 8'hA5, "R2 data latch");
        @(negedge clk);
        bus_addr = 3'd0; bus_wdata = 8'h3C; bus_wr_n = 1'b0;
        repeat (4) @(negedge clk);
        expect_item(1'b1, 8'hA5, "R2 no change while strobe low");
        bus_wr_n = 1'b1;
        repeat (4) @(negedge clk);
        expect_item(1'b1, 8'h3C, "R2 latch after strobe rise");

        pd_in = 8'h5A;
        rd_open(3'd0);
        expect_item(1'b0, 8'h5A, "R3 live pins");
        pd_in = 8'h81;
        @(negedge clk);
        expect_item(1'b0, 8'h81, "R3 pins change mid read");
        rd_close();

        pin_err_n = 1'b0; pin_select = 1'b1; pin_paper_end = 1'b1;
        pin_ack_n = 1'b0; pin_busy = 1'b1;
        repeat (3) @(negedge clk);
        read_check(3'd1, 8'h30, "R4 pattern A");
        pin_err_n = 1'b1; pin_select = 1'b0; pin_paper_end = 1'b0;
        pin_ack_n = 1'b1; pin_busy = 1'b0;
        repeat (3) @(negedge clk);
        read_check(3'd1, 8'hC8, "R4 pattern B");

        rd_open(3'd1);
        expect_item(1'b0, 8'hC8, "R5 first sample");
        pin_err_n = 1'b0; pin_select = 1'b1; pin_busy = 1'b1;
        repeat (5) @(negedge clk);
        expect_item(1'b0, 8'hC8, "R5 frozen during read");
        rd_close();
        read_check(3'd1, 8'h50, "R5 next read sees new pins");

        bus_write(3'd1, 8'hFF);
        expect_item(1'b1, 8'h3C, "R9 status write leaves pins");
        bus_write(3'd5, 8'h77);
        expect_item(1'b1, 8'h3C, "R9 unmapped write ignored");
        read_check(3'd3, 8'h00, "R9 unmapped read zero");

        mode_epp = 1'b1;
        pin_err_n = 1'b1; pin_select = 1'b1; pin_busy = 1'b0;
        repeat (3) @(negedge clk);
        stall(TMO - 20);
        read_check(3'd1, st(1'b0), "R6 short stall no timeout");
        stall(TMO + 20);
        read_check(3'd1, st(1'b1), "R6 long stall sets timeout");
        read_check(3'd1, st(1'b1), "R7 flag sticky");
        bus_write(3'd1, 8'h00);
        read_check(3'd1, st(1'b1), "R7 write zero no effect");
        bus_write(3'd1, 8'h01);
        read_check(3'd1, st(1'b0), "R7 write one clears");

        stall(TMO + 20);
        mode_epp = 1'b0;
        repeat (3) @(negedge clk);
        read_check(3'd1, st(1'b0), "R8 standard mode bit0 zero");
        stall(TMO + 20);
        read_check(3'd1, st(1'b0), "R8 standard mode stall ignored");
        mode_epp = 1'b1;
        repeat (3) @(negedge clk);
        read_check(3'd1, st(1'b0), "R8 earlier flag lost");

        wait (q.size() == 0);
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule